// File: doc/BRIEF.md
# Double-Buffered Route Table Swap Controller

This block decides which half of a routing table is live for each of four traffic directions: receive and transmit on channel A, and receive and transmit on channel B. Each direction owns its own table. Software loads new routing entries into the idle half of a table. It then sets that direction's change-request bit in the command register. At the next frame-sync pulse for that direction, the controller swaps the live and idle halves and clears the request in the same cycle. A status register shows which half is live for each direction.

The slot sequencer supplies an entry index per direction and receives back a table address. The controller forms that address by adding the base of the live half to the index. The base depends on the 2-bit partition mode. Mode 01 uses one channel, with halves of 64 entries at addresses 0 and 64. Mode 11 uses two channels, with halves of 32 entries at addresses 0 and 32. Any other mode leaves the controller idle.

Top module: `route_swap_ctrl`

## Requirements
- R1: After synchronous reset, the command register and the status register both read 0x00.
- R2: In modes 01 and 11, writing the command register with a 1 in bit 7, 6, 5 or 4 sets the request for rx-A, tx-A, rx-B or tx-B respectively. Read bits 3..0 of either register are always zero.
- R3: Writing 0 to a pending request bit leaves the request pending. Only an exchange clears it.
- R4: When a request is pending and the fsync_i bit of that direction is high at a clock edge in mode 01 or 11, the direction's status bit toggles at that edge and its request clears. Other directions are not affected. fsync_i bit 3..0 maps to rx-A, tx-A, rx-B, tx-B.
- R5: A pending request with no frame sync keeps both the request and the status unchanged.
- R6: In modes 00 and 10, command writes are ignored and no exchange occurs, even when a frame sync arrives.
- R7: In mode 01, each direction's address is its 6-bit index plus 64 times its status bit.
- R8: In mode 11, each direction's address is the low 5 bits of its index plus 32 times its status bit.
- R9: In modes 00 and 10, each address equals its index.
- R10: rd_sel_i = 0 reads the command register and rd_sel_i = 1 reads the status register, with rx-A at bit 7 down to tx-B at bit 4. Writes with wr_sel_i = 1 have no effect.
- R11: A set request written in the same cycle as an exchange for that direction stays pending, while the status bit still toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Partition mode: 01 one channel, 11 two channels, other values idle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 command, 1 status (ignored) |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read select: 0 command, 1 status |
| rd_data_o | output | 8 | Read data |
| fsync_i | input | 4 | Frame-sync pulse per direction (bit 3 rx-A ... bit 0 tx-B) |
| idx_i | input | 4*IDX_W | Entry index per direction, direction d at slice d |
| addr_o | output | 4*(IDX_W+1) | Table address per direction, direction d at slice d |

## Verification
The assertions assume that reset is held for at least one clock edge before the first checked cycle, so the previous-cycle samples they use are never undefined. They also assume that the mode input is simply sampled at each edge, with no further constraint on how often it changes. The random stimulus keeps reset high only at the start. It draws the mode from all four values so that the idle modes appear, and it pulses frame sync sparsely so that requests stay pending across several cycles before they are exchanged.

// File: rtl/route_swap_pkg.sv
`timescale 1ns/1ps
package route_swap_pkg;
    localparam int NDIR  = 4;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_ONE = 2'b01,
        MODE_RSV = 2'b10,
        MODE_TWO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic pend;
        logic cur;
    } dir_state_t;

    // partition modes that enable the swap machinery
    function automatic logic mode_live(input logic [1:0] m);
        return (m == MODE_ONE) || (m == MODE_TWO);
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input logic [NDIR-1:0] v);
        return {v, {(REG_W-NDIR){1'b0}}};
    endfunction
endpackage

// File: rtl/route_dir_ctrl.sv
`timescale 1ns/1ps
module route_dir_ctrl
    import route_swap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       live_i,
    input  logic       set_i,
    input  logic       fsync_i,
    output dir_state_t st_o
);
    dir_state_t st_q, st_d;
    logic       swap;

    always_comb begin
        swap      = live_i & st_q.pend & fsync_i;
        st_d.cur  = st_q.cur ^ swap;
        st_d.pend = (st_q.pend & ~swap) | (set_i & live_i);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/route_addr_map.sv
`timescale 1ns/1ps
module route_addr_map
    import route_swap_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [1:0]       mode_i,
    input  logic             cur_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W:0]   addr_o
);
    always_comb begin
        unique case (rmode_e'(mode_i))
            MODE_ONE: addr_o = {cur_i, idx_i};
            MODE_TWO: addr_o = {1'b0, cur_i, idx_i[IDX_W-2:0]};
            default:  addr_o = {1'b0, idx_i};
        endcase
    end
endmodule

// File: rtl/route_reg_if.sv
`timescale 1ns/1ps
module route_reg_if
    import route_swap_pkg::*;
(
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    input  logic [NDIR-1:0]  cmd_i,
    input  logic [NDIR-1:0]  stat_i,
    output logic [NDIR-1:0]  set_o,
    output logic [REG_W-1:0] rd_data_o
);
    always_comb begin
        set_o     = (wr_en_i && !wr_sel_i) ? wr_data_i[REG_W-1 -: NDIR] : '0;
        rd_data_o = rd_sel_i ? pack_reg(stat_i) : pack_reg(cmd_i);
    end
endmodule

// File: rtl/route_swap_ctrl.sv
`timescale 1ns/1ps
module route_swap_ctrl
    import route_swap_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               mode_i,
    input  logic                     wr_en_i,
    input  logic                     wr_sel_i,
    input  logic [7:0]               wr_data_i,
    input  logic                     rd_sel_i,
    output logic [7:0]               rd_data_o,
    input  logic [3:0]               fsync_i,
    input  logic [4*IDX_W-1:0]       idx_i,
    output logic [4*(IDX_W+1)-1:0]   addr_o
);
    localparam int ADDR_W = IDX_W + 1;

    logic            live;
    logic [NDIR-1:0] set_vec, cmd_vec, stat_vec;

    assign live = mode_live(mode_i);

    route_reg_if u_regs (
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .cmd_i     (cmd_vec),
        .stat_i    (stat_vec),
        .set_o     (set_vec),
        .rd_data_o (rd_data_o)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dir_state_t st;

        route_dir_ctrl u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .live_i  (live),
            .set_i   (set_vec[d]),
            .fsync_i (fsync_i[d]),
            .st_o    (st)
        );

        assign cmd_vec[d]  = st.pend;
        assign stat_vec[d] = st.cur;

        route_addr_map #(.IDX_W(IDX_W)) u_map (
            .mode_i (mode_i),
            .cur_i  (st.cur),
            .idx_i  (idx_i[d*IDX_W +: IDX_W]),
            .addr_o (addr_o[d*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: rtl/route_swap_chk.sv
`timescale 1ns/1ps
module route_swap_chk #(
    parameter int IDX_W = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             mode,
    input logic [3:0]             fsync,
    input logic [3:0]             cmd,
    input logic [3:0]             stat,
    input logic [4*IDX_W-1:0]     idx,
    input logic [4*(IDX_W+1)-1:0] addr,
    input logic [7:0]             rd_data
);
    localparam int AW = IDX_W + 1;
    logic ok;
    assign ok = (mode == 2'b01) || (mode == 2'b11);

    // R4
    status_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat == ($past(stat) ^ ($past(cmd) & $past(fsync) & {4{$past(ok)}}))));

    // R3
    no_soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(cmd) & ~cmd) & ~$past(fsync)) == 4'b0));

    // R6
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !ok |=> ($stable(stat) && ((cmd & ~$past(cmd)) == 4'b0)));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[3:0] == 4'b0);

    for (genvar d = 0; d < 4; d++) begin : g_a
        // R7
        single_addr_chk: assert property (@(posedge clk) disable iff (rst)
            (mode == 2'b01) |-> (addr[d*AW +: AW] == {stat[d], idx[d*IDX_W +: IDX_W]}));
        // R8
        dual_addr_chk: assert property (@(posedge clk) disable iff (rst)
            (mode == 2'b11) |-> (addr[d*AW +: AW] ==
                                 {1'b0, stat[d], idx[d*IDX_W +: IDX_W-1]}));
    end
endmodule

bind route_swap_ctrl route_swap_chk #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_i),
    .fsync   (fsync_i),
    .cmd     (cmd_vec),
    .stat    (stat_vec),
    .idx     (idx_i),
    .addr    (addr_o),
    .rd_data (rd_data_o)
);

// File: tb/tb_route_swap_ctrl.sv
`timescale 1ns/1ps
module tb_route_swap_ctrl;
    localparam int IDX_W = 6;
    localparam int AW    = IDX_W + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           mode_i = 2'b00;
    logic                 wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0;
    logic [7:0]           wr_data_i = '0;
    logic [7:0]           rd_data_o;
    logic [3:0]           fsync_i = '0;
    logic [4*IDX_W-1:0]   idx_i = '0;
    logic [4*AW-1:0]      addr_o;

    int   n_run = 0, n_fail = 0;
    logic [3:0] cmd_m = '0, stat_m = '0;

    always #10 clk = ~clk;

    route_swap_ctrl #(.IDX_W(IDX_W)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input logic [1:0] m, input logic c, input logic [IDX_W-1:0] ix);
        if (m == 2'b01) return int'(c) * 64 + int'(ix);
        if (m == 2'b11) return int'(c) * 32 + int'(ix[IDX_W-2:0]);
        return int'(ix);
    endfunction

    // one cycle: drive at negedge, check addresses, clock, update model, check registers
    task automatic tick(input string tag, input logic [1:0] md, input logic wr, input logic sel,
                        input logic [7:0] wd, input logic [3:0] fs, input logic [4*IDX_W-1:0] ix);
        logic       live;
        logic [3:0] setv, swp;
        string      atag;
        mode_i = md; wr_en_i = wr; wr_sel_i = sel; wr_data_i = wd; fsync_i = fs; idx_i = ix;
        #1;
        atag = (md == 2'b01) ? "R7" : (md == 2'b11) ? "R8" : "R9";
        for (int d = 0; d < 4; d++)
            chk(atag, int'(addr_o[d*AW +: AW]), exp_addr(md, stat_m[d], ix[d*IDX_W +: IDX_W]));
        @(posedge clk);
        live = (md == 2'b01) || (md == 2'b11);
        setv = (wr && !sel && live) ? wd[7:4] : 4'b0;
        swp  = cmd_m & fs & {4{live}};
        stat_m = stat_m ^ swp;
        cmd_m  = (cmd_m & ~swp) | setv;
        @(negedge clk);
        wr_en_i = 1'b0; fsync_i = '0;
        rd_sel_i = 1'b0; #1;
        chk(tag, int'(rd_data_o), int'({cmd_m, 4'b0}));
        rd_sel_i = 1'b1; #1;
        chk(tag, int'(rd_data_o), int'({stat_m, 4'b0}));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_sel_i = 1'b0; #1; chk("R1", int'(rd_data_o), 0);
        rd_sel_i = 1'b1; #1; chk("R1", int'(rd_data_o), 0);

        tick("R2",  2'b01, 1'b1, 1'b0, 8'hFF, 4'h0, '0);          // all four set, low bits zero
        tick("R3",  2'b01, 1'b1, 1'b0, 8'h00, 4'h0, '0);          // write 0 keeps pending
        tick("R5",  2'b01, 1'b0, 1'b0, 8'h00, 4'h0, '0);
        tick("R4",  2'b01, 1'b0, 1'b0, 8'h00, 4'b1000, '0);       // rx-A swaps only
        tick("R7",  2'b01, 1'b0, 1'b0, 8'h00, 4'h0, {18'h0, 6'd5}); // rx-A addr 69 at slice 3? slice0 here
        tick("R7",  2'b01, 1'b0, 1'b0, 8'h00, 4'h0, {6'd5, 18'h0}); // rx-A stat 1 -> 64+5
        tick("R4",  2'b11, 1'b0, 1'b0, 8'h00, 4'b0100, '0);       // tx-A swaps
        tick("R8",  2'b11, 1'b0, 1'b0, 8'h00, 4'h0, {6'h25, 6'h3F, 6'h21, 6'h1F});
        tick("R6",  2'b00, 1'b1, 1'b0, 8'hFF, 4'hF, {6'h25, 6'h3F, 6'h21, 6'h1F});
        tick("R6",  2'b10, 1'b1, 1'b0, 8'hC0, 4'hF, '0);
        tick("R9",  2'b10, 1'b0, 1'b0, 8'h00, 4'h0, {6'h3F, 6'h2A, 6'h15, 6'h01});
        tick("R10", 2'b11, 1'b1, 1'b1, 8'h00, 4'h0, '0);          // status write ignored
        tick("R10", 2'b11, 1'b1, 1'b1, 8'hF0, 4'h0, '0);
        tick("R11", 2'b11, 1'b1, 1'b0, 8'h20, 4'b0010, '0);       // rx-B swap + re-set
        tick("R11", 2'b11, 1'b0, 1'b0, 8'h00, 4'b0010, '0);       // second swap consumes it

        for (int i = 0; i < 600; i++) begin
            logic [1:0] md;
            int r;
            r  = $urandom_range(0, 9);
            md = (r < 4) ? 2'b01 : (r < 8) ? 2'b11 : (r == 8) ? 2'b00 : 2'b10;
            tick("R4", md, ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
                 8'($urandom), 4'($urandom) & 4'($urandom), {$urandom} [4*IDX_W-1:0]);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule